// File: doc/BRIEF.md
# Byte-Oriented I2C Target Controller

This block answers an I2C controller on the bus as a 7-bit addressed target, using a small four-entry register window on the host side. Both bus lines first pass through a synchronizer and a debounce counter that is sized to reject spikes shorter than 50 ns. A transaction begins when a start condition is seen. The controller then shifts in eight bits and compares the upper seven with the programmed address. On a match it acknowledges, records the direction bit and raises an interrupt flag. The host can tell an address interrupt from a data-byte interrupt only through its own software state, because both raise the same flag.

Each later byte is handled in one of two ways. In the write direction the controller receives the byte, acknowledges it, stores it in the data register and raises the flag. In the read direction it shifts out the byte the host loaded, most significant bit first, and raises the flag only when the bus controller acknowledges. While the flag is pending, the block holds SCL low. Any read or write of the data register drops the flag and releases SCL.

A data-register access made when no flag is pending is treated as a protocol error, and the controller halts. Only the software reset bit brings it back.

Top module: `i2cs_top`

## Requirements
- R1: After reset the flag is 0, both line pull-downs are released, the status register (select 3: bit0 flag, bit1 direction, bit2 halted) reads 0 and the address register (select 1, bits 6:0) holds DEF_ADDR. A write to select 1 updates it.
- R2: After a start, an address byte whose bits 7:1 equal the address register is acknowledged by pulling SDA low during the ninth clock. The flag rises right after that ninth clock's falling edge, and the data register (select 2) then reads the whole address byte, with the direction bit in bit0.
- R3: An address that does not match is not acknowledged and raises no flag. Every following byte is also ignored until the next start condition.
- R4: The direction bit of a matched address byte appears as status bit1 (1 = the target sends data).
- R5: While the flag is pending, SCL is held low. It is released once the flag clears.
- R6: A read or a write of the data register while the flag is pending clears the flag.
- R7: In the write direction each data byte is acknowledged, is readable from the data register, and raises the flag.
- R8: In the read direction the byte written to the data register is driven on SDA, MSB first. A controller ACK on the ninth clock raises the flag. A NACK raises none and returns the block to idle.
- R9: A data-register access while the flag is clear sets status bit2. A halted block drives neither line, ignores all bus traffic and raises no flag.
- R10: A stop condition returns the block to idle. Bytes clocked after it are not acknowledged until a new start and a matching address arrive.
- R11: Writing 1 to bit0 of select 0 returns the block to idle, clears the flag, the direction bit and the halt, and releases both lines.
- R12: A pulse on either line shorter than the filter length (50 ns in system clocks) has no effect. An SCL spike in the middle of an address byte does not add a bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| scl_pull | output | 1 | 1 pulls SCL low (open-drain) |
| sda_pull | output | 1 | 1 pulls SDA low (open-drain) |
| reg_sel | input | 2 | Register select: 0 control, 1 address, 2 data, 3 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for the selected register |
| irq | output | 1 | Pending byte flag |

## Verification
The bench plays the bus controller and drives several input patterns.

- **Address handling.** A foreign address, followed by a byte equal to the own write address but sent without a start, separates address matching from start detection. Bytes sent after a stop separate a proper return to idle from a stale addressed state.
- **Write and read directions.** Write transactions carrying complementary data bytes, and a read transaction ended first with ACK and then with NACK, show whether the flag follows the acknowledge of each byte.
- **Stretching and access counting.** A byte clocked while the flag is pending shows the stretch. A double read shows the halt and its recovery by soft reset.
- **Spike filter.** A short SCL spike inside an address byte tells a working filter from a missing one.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ACKOUT,
    ST_RX,
    ST_TX,
    ST_TXACK,
    ST_HALT
  } i2cs_state_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_ADDR = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  // system clocks needed to cover a spike window (rounded up)
  function automatic int filt_cycles(input int clk_ps, input int spike_ps);
    int n;
    n = (spike_ps + clk_ps - 1) / clk_ps;
    return (n < 1) ? 1 : n;
  endfunction

  // address byte carries the 7-bit address in bits 7:1
  function automatic logic addr_hit(input logic [7:0] sh, input logic [6:0] own);
    return sh[7:1] == own;
  endfunction

endpackage

// File: rtl/i2cs_filter.sv
module i2cs_filter #(
  parameter int   LEN  = 10,
  parameter logic INIT = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic dout
);
  localparam int CW = $clog2(LEN + 1);

  logic [1:0]    sync_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= {INIT, INIT};
      cnt_q  <= '0;
      dout   <= INIT;
    end else begin
      sync_q <= {sync_q[0], din};
      if (sync_q[1] == dout) begin
        cnt_q <= '0;
      end else if (cnt_q == CW'(LEN - 1)) begin
        dout  <= sync_q[1];
        cnt_q <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/i2cs_cond.sv
module i2cs_cond (
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic sda,
  output logic ev_start,
  output logic ev_stop,
  output logic ev_rise,
  output logic ev_fall
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl;
      sda_q <= sda;
    end
  end

  assign ev_rise  = scl & ~scl_q;
  assign ev_fall  = ~scl & scl_q;
  assign ev_start = scl & scl_q & sda_q & ~sda;
  assign ev_stop  = scl & scl_q & ~sda_q & sda;
endmodule

// File: rtl/i2cs_core.sv
module i2cs_core
  import i2cs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sda,
  input  logic       ev_start,
  input  logic       ev_stop,
  input  logic       ev_rise,
  input  logic       ev_fall,
  input  logic [6:0] own_addr,
  input  logic       data_acc,
  input  logic       data_wr,
  input  logic [7:0] wdata,
  input  logic       soft_rst,
  output logic [7:0] data_q,
  output logic       flag,
  output logic       tx_dir,
  output logic       halted,
  output logic       sda_low
);
  i2cs_state_e state;
  logic [7:0]  shreg;
  logic [3:0]  bitcnt;
  logic        mack;
  logic [7:0]  tx_byte;

  assign tx_byte = data_wr ? wdata : data_q;
  assign halted  = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      shreg   <= '0;
      bitcnt  <= '0;
      mack    <= 1'b0;
      data_q  <= '0;
      flag    <= 1'b0;
      tx_dir  <= 1'b0;
      sda_low <= 1'b0;
    end else if (soft_rst) begin
      state   <= ST_IDLE;
      bitcnt  <= '0;
      flag    <= 1'b0;
      tx_dir  <= 1'b0;
      sda_low <= 1'b0;
    end else if (state == ST_HALT) begin
      sda_low <= 1'b0;
    end else if (data_acc && !flag) begin
      state   <= ST_HALT;
      sda_low <= 1'b0;
    end else begin
      if (data_acc) begin
        flag <= 1'b0;
        if (data_wr) data_q <= wdata;
        if (state == ST_TX) begin
          shreg   <= tx_byte;
          sda_low <= ~tx_byte[7];
          bitcnt  <= '0;
        end
      end
      if (ev_start) begin
        state   <= ST_ADDR;
        bitcnt  <= '0;
        sda_low <= 1'b0;
      end else if (ev_stop) begin
        state   <= ST_IDLE;
        sda_low <= 1'b0;
      end else if (ev_rise) begin
        case (state)
          ST_ADDR, ST_RX: begin
            shreg  <= {shreg[6:0], sda};
            bitcnt <= bitcnt + 1'b1;
          end
          ST_TX:    bitcnt <= bitcnt + 1'b1;
          ST_TXACK: mack   <= ~sda;
          default: ;
        endcase
      end else if (ev_fall) begin
        case (state)
          ST_ADDR: if (bitcnt == 4'd8) begin
            if (addr_hit(shreg, own_addr)) begin
              data_q  <= shreg;
              tx_dir  <= shreg[0];
              sda_low <= 1'b1;
              state   <= ST_ACKOUT;
            end else begin
              state <= ST_IDLE;
            end
          end
          ST_RX: if (bitcnt == 4'd8) begin
            data_q  <= shreg;
            sda_low <= 1'b1;
            state   <= ST_ACKOUT;
          end
          ST_ACKOUT: begin
            sda_low <= 1'b0;
            flag    <= 1'b1;
            bitcnt  <= '0;
            state   <= tx_dir ? ST_TX : ST_RX;
          end
          ST_TX: if (bitcnt == 4'd8) begin
            sda_low <= 1'b0;
            state   <= ST_TXACK;
          end else begin
            shreg   <= {shreg[6:0], 1'b0};
            sda_low <= ~shreg[6];
          end
          ST_TXACK: if (mack) begin
            flag   <= 1'b1;
            bitcnt <= '0;
            state  <= ST_TX;
          end else begin
            state <= ST_IDLE;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2cs_top.sv
module i2cs_top
  import i2cs_pkg::*;
#(
  parameter int         CLK_PS   = 5000,
  parameter int         SPIKE_PS = 50000,
  parameter logic [6:0] DEF_ADDR = 7'h3A
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_in,
  input  logic       sda_in,
  output logic       scl_pull,
  output logic       sda_pull,
  input  logic [1:0] reg_sel,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq
);
  localparam int FILT = filt_cycles(CLK_PS, SPIKE_PS);

  logic       scl_f, sda_f;
  logic       ev_start_w, ev_stop_w, ev_rise_w, ev_fall_w;
  logic [6:0] own_addr_q;
  logic       data_acc_w, soft_rst_w;
  logic [7:0] data_w;
  logic       flag_w, tx_dir_w, halted_w, sda_low_w;

  logic [1:0] line_raw, line_flt;
  assign line_raw = {scl_in, sda_in};
  assign scl_f    = line_flt[1];
  assign sda_f    = line_flt[0];

  for (genvar g = 0; g < 2; g++) begin : g_filt
    i2cs_filter #(.LEN(FILT), .INIT(1'b1)) u_filt (
      .clk(clk), .rst_n(rst_n), .din(line_raw[g]), .dout(line_flt[g])
    );
  end

  i2cs_cond u_cond (
    .clk(clk), .rst_n(rst_n), .scl(scl_f), .sda(sda_f),
    .ev_start(ev_start_w), .ev_stop(ev_stop_w),
    .ev_rise(ev_rise_w), .ev_fall(ev_fall_w)
  );

  assign data_acc_w = (reg_wr | reg_rd) && (reg_sel == SEL_DATA);
  assign soft_rst_w = reg_wr && (reg_sel == SEL_CTRL) && reg_wdata[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                            own_addr_q <= DEF_ADDR;
    else if (reg_wr && reg_sel == SEL_ADDR) own_addr_q <= reg_wdata[6:0];
  end

  i2cs_core u_core (
    .clk(clk), .rst_n(rst_n), .sda(sda_f),
    .ev_start(ev_start_w), .ev_stop(ev_stop_w),
    .ev_rise(ev_rise_w), .ev_fall(ev_fall_w),
    .own_addr(own_addr_q), .data_acc(data_acc_w), .data_wr(reg_wr),
    .wdata(reg_wdata), .soft_rst(soft_rst_w),
    .data_q(data_w), .flag(flag_w), .tx_dir(tx_dir_w),
    .halted(halted_w), .sda_low(sda_low_w)
  );

  always_comb begin
    unique case (reg_sel)
      SEL_CTRL: reg_rdata = 8'h00;
      SEL_ADDR: reg_rdata = {1'b0, own_addr_q};
      SEL_DATA: reg_rdata = data_w;
      default:  reg_rdata = {5'b0, halted_w, tx_dir_w, flag_w};
    endcase
  end

  assign irq      = flag_w;
  assign scl_pull = flag_w;
  assign sda_pull = sda_low_w;
endmodule

// File: rtl/i2cs_checker.sv
module i2cs_checker (
  input logic clk,
  input logic rst_n,
  input logic irq,
  input logic halted,
  input logic scl_pull,
  input logic sda_pull,
  input logic ev_fall,
  input logic ev_stop,
  input logic data_acc,
  input logic soft_rst
);
  AST_FLAG_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(ev_fall)); // R2

  AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && irq) |=> !irq); // R6

  AST_STRETCH_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !halted) |-> scl_pull); // R5

  AST_EXTRA_ACCESS_HALTS: assert property (@(posedge clk) disable iff (!rst_n)
    (data_acc && !irq && !soft_rst) |=> halted); // R9

  AST_HALT_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> (!sda_pull && !scl_pull && !irq)); // R9

  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_stop && !data_acc) |=> !sda_pull); // R10

  AST_SOFT_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst |=> (!irq && !halted && !sda_pull && !scl_pull)); // R11
endmodule

bind i2cs_top i2cs_checker u_chk (
  .clk(clk), .rst_n(rst_n), .irq(irq), .halted(halted_w),
  .scl_pull(scl_pull), .sda_pull(sda_pull), .ev_fall(ev_fall_w),
  .ev_stop(ev_stop_w), .data_acc(data_acc_w), .soft_rst(soft_rst_w)
);

// File: tb/i2cs_top_tb.sv
module i2cs_top_tb;
  localparam int Q  = 20;
  localparam int HP = 40;
  localparam logic [6:0] OWN = 7'h52;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic       m_scl = 1'b1, m_sda = 1'b1;
  logic       scl_pull, sda_pull, irq;
  logic [1:0] reg_sel = 2'd0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [7:0] reg_wdata = 8'h00, reg_rdata;
  wire        scl_bus = m_scl & ~scl_pull;
  wire        sda_bus = m_sda & ~sda_pull;

  i2cs_top u_dut (
    .clk(clk), .rst_n(rst_n), .scl_in(scl_bus), .sda_in(sda_bus),
    .scl_pull(scl_pull), .sda_pull(sda_pull), .reg_sel(reg_sel),
    .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq(irq)
  );

  int total = 0, fails = 0;
  bit m_halted = 0;        // reference model: block expected halted
  bit done = 0;
  logic [7:0] exp_q[$];    // bytes expected in the data register

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) if (rst_n && !done) begin
    check("R5 pull only with flag", (scl_pull && !irq), 0);
    if (m_halted) check("R9 halted lines idle", {scl_pull, sda_pull, irq}, 3'b000);
  end

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 v = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic wr(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic mbit(input logic b, input bit glitch, output logic smp);
    wait_n(Q); m_sda = b; wait_n(Q);
    if (glitch) begin m_scl = 1'b1; wait_n(4); m_scl = 1'b0; wait_n(Q); end
    m_scl = 1'b1;
    while (scl_bus !== 1'b1) @(negedge clk);
    wait_n(Q); smp = sda_bus; wait_n(Q);
    m_scl = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b, input int gl, output logic ack);
    logic s;
    for (int i = 7; i >= 0; i--) mbit(b[i], (gl == i), s);
    mbit(1'b1, 1'b0, s);
    ack = ~s;
    wait_n(30);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic s;
    for (int i = 7; i >= 0; i--) begin mbit(1'b1, 1'b0, s); b[i] = s; end
    mbit(~give_ack, 1'b0, s);
    wait_n(30);
  endtask

  task automatic mstart();
    m_sda = 1'b1; m_scl = 1'b1; wait_n(HP);
    m_sda = 1'b0; wait_n(HP);
    m_scl = 1'b0;
  endtask

  task automatic mstop();
    m_scl = 1'b0; wait_n(Q); m_sda = 1'b0; wait_n(Q);
    m_scl = 1'b1;
    while (scl_bus !== 1'b1) @(negedge clk);
    wait_n(HP); m_sda = 1'b1; wait_n(HP);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic a;
    wait_n(5); rst_n = 1'b1; wait_n(3);

    // R1 reset state
    check("R1 irq", irq, 0);
    check("R1 pulls", {scl_pull, sda_pull}, 0);
    rd(2'd3, v); check("R1 status", v, 8'h00);
    rd(2'd1, v); check("R1 default address", v, 8'h3A);
    wr(2'd1, {1'b0, OWN});
    rd(2'd1, v); check("R1 address write", v, {1'b0, OWN});

    // R3 foreign address, then own address byte without start
    mstart();
    send_byte({7'h50, 1'b0}, -1, a); check("R3 no ack foreign", a, 0);
    check("R3 no flag", irq, 0);
    send_byte({OWN, 1'b0}, -1, a); check("R3 ignored until start", a, 0);
    check("R3 no flag later", irq, 0);
    mstop();

    // R2/R4/R5/R6/R7 write direction
    mstart();
    send_byte({OWN, 1'b0}, -1, a); check("R2 address ack", a, 1);
    check("R2 flag after address", irq, 1);
    rd(2'd3, v); check("R4 direction write", v[1], 0);
    exp_q.push_back({OWN, 1'b0});
    exp_q.push_back(8'h3C);
    fork
      send_byte(8'h3C, -1, a);
      begin
        wait_n(150);
        check("R5 scl held low", scl_bus, 0);
        rd(2'd2, v); check("R2 data holds address byte", v, exp_q.pop_front());
        wait_n(2);
        check("R6 read clears flag", irq, 0);
      end
    join
    check("R7 data ack", a, 1);
    check("R7 flag on data", irq, 1);
    rd(2'd2, v); check("R7 byte 1", v, exp_q.pop_front());
    exp_q.push_back(8'hC3);
    send_byte(8'hC3, -1, a); check("R7 data ack 2", a, 1);
    rd(2'd2, v); check("R7 byte 2", v, exp_q.pop_front());
    mstop();
    m_scl = 1'b0; wait_n(Q);
    send_byte({OWN, 1'b0}, -1, a); check("R10 idle after stop", a, 0);
    check("R10 no flag", irq, 0);
    mstop();

    // R4/R8 read direction
    mstart();
    send_byte({OWN, 1'b1}, -1, a); check("R2 read address ack", a, 1);
    rd(2'd3, v); check("R4 direction read", v, 8'h03);
    wr(2'd2, 8'h96);
    check("R6 write clears flag", irq, 0);
    recv_byte(1'b1, v); check("R8 byte sent", v, 8'h96);
    check("R8 flag after ack", irq, 1);
    wr(2'd2, 8'h5B);
    recv_byte(1'b0, v); check("R8 second byte", v, 8'h5B);
    check("R8 no flag after nack", irq, 0);
    mstop();

    // R9 second access halts
    mstart();
    send_byte({OWN, 1'b0}, -1, a); check("R2 ack before halt", a, 1);
    rd(2'd2, v);
    rd(2'd2, v);
    m_halted = 1;
    rd(2'd3, v); check("R9 halted status", v[2], 1);
    send_byte(8'h11, -1, a); check("R9 no ack while halted", a, 0);
    mstop();
    mstart();
    send_byte({OWN, 1'b0}, -1, a); check("R9 address ignored", a, 0);
    mstop();

    // R11 soft reset
    wr(2'd0, 8'h01); m_halted = 0;
    rd(2'd3, v); check("R11 status cleared", v, 8'h00);
    mstart();
    send_byte({OWN, 1'b0}, -1, a); check("R11 ack after reset", a, 1);
    check("R11 flag pending", irq, 1);
    wr(2'd0, 8'h01); wait_n(2);
    check("R11 flag and pulls cleared", {irq, scl_pull, sda_pull}, 3'b000);
    mstop();

    // R12 SCL spike inside the address byte
    mstart();
    send_byte({OWN, 1'b0}, 3, a); check("R12 spike rejected", a, 1);
    rd(2'd2, v); check("R12 address intact", v, {OWN, 1'b0});
    mstop();

    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule